// File: doc/BRIEF.md
# Load-Locked Reservation Tag Unit

This block keeps the reservation state for a split load-locked / store-conditional pair inside a load-store unit that holds several line buffers. A tagged load marks one 64-bit word of one line as reserved. A later conditional store to that word succeeds only if the mark is still present. The block returns a one-bit result that the core writes back to a register, and it produces the byte write enables for the store. Any store that reaches a word removes that word's mark. A flush pulse, raised on a task switch or on interrupt entry, removes every mark at once. A reservation therefore cannot be lost and set again between the load and the store without the store noticing.

Each line holds several 64-bit words, and each word has one reservation bit. The block also keeps a sticky dirty bit for each 32-bit half of every word. A dirty bit is set whenever a store actually writes at least one byte of that half. The data path, line refill and atomics from remote processors are handled elsewhere.

Top module: `resv_tag_unit`

## Requirements
- R1: After reset, all reservations and all dirty bits are clear, and `sc_done_o`, `sc_ok_o` and `wr_be_o` are zero.
- R2: A conditional store to a word reserved by an earlier load-tag reports `sc_done_o`=1 and `sc_ok_o`=1 on the cycle after it is presented, and `wr_be_o` equals its byte mask.
- R3: A conditional store to an unreserved word reports `sc_done_o`=1 and `sc_ok_o`=0, drives `wr_be_o` to all zeros, and leaves the dirty bits unchanged.
- R4: A reservation covers one 64-bit word only. Word index = line*WORDS_PER_LINE + word, and tagging one word does not reserve any other word or line.
- R5: A plain store always writes (`wr_be_o` equals its mask one cycle later) and clears the reservation of its word, so a following conditional store to that word fails.
- R6: A successful conditional store clears its own reservation, so a second conditional store to the same word fails.
- R7: A flush pulse clears every reservation. A conditional store presented in the same cycle as the flush fails.
- R8: If a load-tag and a store address the same word in the same cycle, the clear wins and the word is left unreserved.
- R9: `dirty_o` holds one bit per 32-bit half at index 2*word_index + h. Half h=0 covers byte enables [3:0] and h=1 covers [7:4]. A bit is set when a performed write has any enable in its half, and it stays set until reset. A flush does not clear it.
- R10: `sc_done_o` is 1 exactly on the cycle after a conditional store is presented, and 0 otherwise. `sc_ok_o` is 0 whenever `sc_done_o` is 0. `wr_be_o` is 0 on the cycle after a cycle with no store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ld_tag_i | input | 1 | Load-locked issued this cycle; sets a reservation |
| ld_line_i | input | 2 | Line buffer index of the tagged load |
| ld_word_i | input | 2 | 64-bit word offset of the tagged load |
| st_valid_i | input | 1 | Store issued this cycle |
| st_cond_i | input | 1 | The store is conditional |
| st_line_i | input | 2 | Line buffer index of the store |
| st_word_i | input | 2 | 64-bit word offset of the store |
| st_be_i | input | 8 | Requested byte mask of the store |
| flush_i | input | 1 | Task switch or interrupt entry; clears all reservations |
| sc_done_o | output | 1 | Conditional-store result valid |
| sc_ok_o | output | 1 | Conditional-store success flag for write-back |
| wr_be_o | output | 8 | Byte write enables actually applied |
| dirty_o | output | 32 | Dirty bit per 32-bit half-word |

## Verification
Every result is registered, so the outputs that follow a stimulus presented before clock edge N are valid from edge N until edge N+1. This covers `sc_done_o`, `sc_ok_o`, `wr_be_o` and the updated `dirty_o`. A changed reservation is first seen by a store presented in the cycle after edge N. The bench drives each stimulus on a falling edge and checks the results of that stimulus on the next falling edge, half a cycle after the edge that registers them. Its expected reservation and dirty model is updated at the same step.

// File: rtl/resv_pkg.sv
package resv_pkg;

    typedef enum logic [1:0] {
        ST_NONE  = 2'd0,
        ST_PLAIN = 2'd1,
        ST_COND  = 2'd2
    } st_kind_e;

    function automatic st_kind_e classify_store(input logic valid, input logic cond);
        if (!valid)   return ST_NONE;
        else if (cond) return ST_COND;
        else           return ST_PLAIN;
    endfunction

endpackage

// File: rtl/resv_tag_array.sv
module resv_tag_array #(
    parameter int NUM_SLOTS = 16,
    localparam int IDX_W = $clog2(NUM_SLOTS)
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 set_en_i,
    input  logic [IDX_W-1:0]     set_idx_i,
    input  logic                 clr_en_i,
    input  logic [IDX_W-1:0]     clr_idx_i,
    input  logic                 clr_all_i,
    output logic [NUM_SLOTS-1:0] tags_o
);

    typedef struct packed {
        logic [NUM_SLOTS-1:0] tags;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (clr_all_i) begin
                state_d.tags[s] = 1'b0;
            end else if (clr_en_i && (clr_idx_i == IDX_W'(s))) begin
                state_d.tags[s] = 1'b0;
            end else if (set_en_i && (set_idx_i == IDX_W'(s))) begin
                state_d.tags[s] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    assign tags_o = state_q.tags;

endmodule

// File: rtl/resv_store_gate.sv
module resv_store_gate
    import resv_pkg::*;
#(
    parameter int BE_W = 8
) (
    input  logic            st_valid_i,
    input  logic            st_cond_i,
    input  logic            tag_hit_i,
    input  logic            flush_i,
    input  logic [BE_W-1:0] be_i,
    output logic            is_cond_o,
    output logic            ok_o,
    output logic            write_o,
    output logic [BE_W-1:0] be_o
);

    st_kind_e kind;

    always_comb begin
        kind      = classify_store(st_valid_i, st_cond_i);
        is_cond_o = 1'b0;
        ok_o      = 1'b0;
        write_o   = 1'b0;
        unique case (kind)
            ST_PLAIN: write_o = 1'b1;
            ST_COND: begin
                is_cond_o = 1'b1;
                ok_o      = tag_hit_i && !flush_i;
                write_o   = ok_o;
            end
            default: ;
        endcase
        be_o = write_o ? be_i : '0;
    end

endmodule

// File: rtl/resv_dirty_track.sv
module resv_dirty_track #(
    parameter int NUM_SLOTS   = 16,
    parameter int WORD_BYTES  = 8,
    parameter int DIRTY_BYTES = 4,
    localparam int IDX_W      = $clog2(NUM_SLOTS),
    localparam int HALVES     = WORD_BYTES / DIRTY_BYTES,
    localparam int NUM_DIRTY  = NUM_SLOTS * HALVES
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  wr_en_i,
    input  logic [IDX_W-1:0]      wr_idx_i,
    input  logic [WORD_BYTES-1:0] wr_be_i,
    output logic [NUM_DIRTY-1:0]  dirty_o
);

    typedef struct packed {
        logic [NUM_DIRTY-1:0] dirty;
    } state_t;

    state_t state_d, state_q;
    logic [HALVES-1:0] part_hit;

    for (genvar h = 0; h < HALVES; h++) begin : g_part
        assign part_hit[h] = |wr_be_i[h*DIRTY_BYTES +: DIRTY_BYTES];
    end

    always_comb begin
        state_d = state_q;
        if (wr_en_i) begin
            for (int s = 0; s < NUM_SLOTS; s++) begin
                if (wr_idx_i == IDX_W'(s)) begin
                    for (int h = 0; h < HALVES; h++) begin
                        if (part_hit[h]) state_d.dirty[s*HALVES + h] = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    assign dirty_o = state_q.dirty;

endmodule

// File: rtl/resv_tag_unit.sv
module resv_tag_unit #(
    parameter int NUM_LINES      = 4,
    parameter int WORDS_PER_LINE = 4,
    parameter int WORD_BYTES     = 8,
    parameter int DIRTY_BYTES    = 4,
    localparam int LINE_W        = $clog2(NUM_LINES),
    localparam int WORD_W        = $clog2(WORDS_PER_LINE),
    localparam int NUM_SLOTS     = NUM_LINES * WORDS_PER_LINE,
    localparam int IDX_W         = LINE_W + WORD_W,
    localparam int NUM_DIRTY     = NUM_SLOTS * (WORD_BYTES / DIRTY_BYTES)
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  ld_tag_i,
    input  logic [LINE_W-1:0]     ld_line_i,
    input  logic [WORD_W-1:0]     ld_word_i,
    input  logic                  st_valid_i,
    input  logic                  st_cond_i,
    input  logic [LINE_W-1:0]     st_line_i,
    input  logic [WORD_W-1:0]     st_word_i,
    input  logic [WORD_BYTES-1:0] st_be_i,
    input  logic                  flush_i,
    output logic                  sc_done_o,
    output logic                  sc_ok_o,
    output logic [WORD_BYTES-1:0] wr_be_o,
    output logic [NUM_DIRTY-1:0]  dirty_o
);

    typedef struct packed {
        logic                  sc_done;
        logic                  sc_ok;
        logic [WORD_BYTES-1:0] wr_be;
    } out_t;

    out_t out_d, out_q;

    logic [IDX_W-1:0]      ld_idx, st_idx;
    logic [NUM_SLOTS-1:0]  tags;
    logic                  tag_hit;
    logic                  is_cond, ok, write;
    logic [WORD_BYTES-1:0] gated_be;

    assign ld_idx  = {ld_line_i, ld_word_i};
    assign st_idx  = {st_line_i, st_word_i};
    assign tag_hit = tags[st_idx];

    resv_tag_array #(.NUM_SLOTS(NUM_SLOTS)) u_tags (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .set_en_i  (ld_tag_i),
        .set_idx_i (ld_idx),
        .clr_en_i  (st_valid_i),
        .clr_idx_i (st_idx),
        .clr_all_i (flush_i),
        .tags_o    (tags)
    );

    resv_store_gate #(.BE_W(WORD_BYTES)) u_gate (
        .st_valid_i (st_valid_i),
        .st_cond_i  (st_cond_i),
        .tag_hit_i  (tag_hit),
        .flush_i    (flush_i),
        .be_i       (st_be_i),
        .is_cond_o  (is_cond),
        .ok_o       (ok),
        .write_o    (write),
        .be_o       (gated_be)
    );

    resv_dirty_track #(
        .NUM_SLOTS   (NUM_SLOTS),
        .WORD_BYTES  (WORD_BYTES),
        .DIRTY_BYTES (DIRTY_BYTES)
    ) u_dirty (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_en_i  (write),
        .wr_idx_i (st_idx),
        .wr_be_i  (gated_be),
        .dirty_o  (dirty_o)
    );

    always_comb begin
        out_d         = out_q;
        out_d.sc_done = is_cond;
        out_d.sc_ok   = ok;
        out_d.wr_be   = gated_be;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) out_q <= '0;
        else         out_q <= out_d;
    end

    assign sc_done_o = out_q.sc_done;
    assign sc_ok_o   = out_q.sc_ok;
    assign wr_be_o   = out_q.wr_be;

endmodule

// File: rtl/resv_tag_unit_chk.sv
module resv_tag_unit_chk #(
    parameter int WORD_BYTES = 8,
    parameter int NUM_DIRTY  = 32
) (
    input logic                  clk_i,
    input logic                  rst_ni,
    input logic                  st_valid_i,
    input logic                  st_cond_i,
    input logic                  flush_i,
    input logic                  sc_done_o,
    input logic                  sc_ok_o,
    input logic [WORD_BYTES-1:0] wr_be_o,
    input logic [NUM_DIRTY-1:0]  dirty_o
);

    p_fail_no_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sc_done_o && !sc_ok_o) |-> (wr_be_o == '0));

    p_idle_no_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !st_valid_i |=> (wr_be_o == '0));

    p_flush_kills_sc_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flush_i && st_valid_i && st_cond_i) |=> (sc_done_o && !sc_ok_o));

    p_dirty_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (($past(dirty_o) & ~dirty_o) == '0));

    p_done_follows_cond_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_valid_i && st_cond_i) |=> sc_done_o);

    p_no_done_without_cond_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(st_valid_i && st_cond_i) |=> !sc_done_o);

    p_ok_needs_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sc_done_o |-> !sc_ok_o);

endmodule

bind resv_tag_unit resv_tag_unit_chk #(
    .WORD_BYTES (WORD_BYTES),
    .NUM_DIRTY  (NUM_DIRTY)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .st_valid_i (st_valid_i),
    .st_cond_i  (st_cond_i),
    .flush_i    (flush_i),
    .sc_done_o  (sc_done_o),
    .sc_ok_o    (sc_ok_o),
    .wr_be_o    (wr_be_o),
    .dirty_o    (dirty_o)
);

// File: tb/resv_tag_unit_tb_top.sv
module resv_tag_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NW = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_tag = 1'b0;
    logic [1:0]  ld_line = '0, ld_word = '0;
    logic        st_valid = 1'b0, st_cond = 1'b0;
    logic [1:0]  st_line = '0, st_word = '0;
    logic [7:0]  st_be = '0;
    logic        flush = 1'b0;
    logic        sc_done, sc_ok;
    logic [7:0]  wr_be;
    logic [31:0] dirty;

    int checks = 0;
    int failures = 0;
    logic [NW-1:0] m_tags = '0;
    logic [31:0]   m_dirty = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    resv_tag_unit dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .ld_tag_i(ld_tag), .ld_line_i(ld_line), .ld_word_i(ld_word),
        .st_valid_i(st_valid), .st_cond_i(st_cond),
        .st_line_i(st_line), .st_word_i(st_word), .st_be_i(st_be),
        .flush_i(flush),
        .sc_done_o(sc_done), .sc_ok_o(sc_ok), .wr_be_o(wr_be), .dirty_o(dirty)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic ld, input int ldi, input logic sv, input logic sc,
                        input int sti, input logic [7:0] be, input logic fl, input string req);
        logic       e_done, e_ok;
        logic [7:0] e_be;
        ld_tag = ld; ld_line = 2'(ldi / 4); ld_word = 2'(ldi % 4);
        st_valid = sv; st_cond = sc; st_line = 2'(sti / 4); st_word = 2'(sti % 4);
        st_be = be; flush = fl;
        e_done = sv && sc;
        e_ok   = e_done && m_tags[sti] && !fl;
        e_be   = (sv && (!sc || e_ok)) ? be : 8'h00;
        if (|e_be[3:0]) m_dirty[2*sti]     = 1'b1;
        if (|e_be[7:4]) m_dirty[2*sti + 1] = 1'b1;
        if (fl) m_tags = '0;
        else begin
            if (ld) m_tags[ldi] = 1'b1;
            if (sv) m_tags[sti] = 1'b0;
        end
        @(negedge clk);
        check(req, "sc_done", 32'(sc_done), 32'(e_done));
        check(req, "sc_ok", 32'(sc_ok), 32'(e_ok));
        check(req, "wr_be", 32'(wr_be), 32'(e_be));
        check("R9", "dirty", dirty, m_dirty);
    endtask

    task automatic idle();
        step(1'b0, 0, 1'b0, 1'b0, 0, 8'h00, 1'b0, "R10");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "sc_done", 32'(sc_done), 0);
        check("R1", "wr_be", 32'(wr_be), 0);
        check("R1", "dirty", dirty, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: no reservation after reset, conditional store fails
        step(1'b0, 0, 1'b1, 1'b1, 5, 8'hFF, 1'b0, "R1");
        idle();

        // R2 / R3 / R4: each word reserved in turn, conditional stores swept over all words
        for (int t = 0; t < NW; t++) begin
            step(1'b0, 0, 1'b0, 1'b0, 0, 8'h00, 1'b1, "R7");
            step(1'b1, t, 1'b0, 1'b0, 0, 8'h00, 1'b0, "R4");
            for (int w = 0; w < NW; w++) begin
                step(1'b0, 0, 1'b1, 1'b1, w, 8'((t*37 + w*11 + 1) % 256),
                     1'b0, (w == t) ? "R2" : "R4");
            end
        end

        // R5: plain store clears a reservation and always writes
        for (int t = 0; t < NW; t++) begin
            step(1'b1, t, 1'b0, 1'b0, 0, 8'h00, 1'b0, "R5");
            step(1'b0, 0, 1'b1, 1'b0, t, 8'((t*13) % 256), 1'b0, "R5");
            step(1'b0, 0, 1'b1, 1'b1, t, 8'hFF, 1'b0, "R5");
        end

        // R6: second conditional store to the same word fails
        for (int t = 0; t < NW; t += 3) begin
            step(1'b1, t, 1'b0, 1'b0, 0, 8'h00, 1'b0, "R6");
            step(1'b0, 0, 1'b1, 1'b1, t, 8'h0F, 1'b0, "R6");
            step(1'b0, 0, 1'b1, 1'b1, t, 8'hF0, 1'b0, "R6");
        end

        // R7: flush wipes all reservations
        for (int t = 0; t < NW; t++) step(1'b1, t, 1'b0, 1'b0, 0, 8'h00, 1'b0, "R7");
        step(1'b0, 0, 1'b0, 1'b0, 0, 8'h00, 1'b1, "R7");
        for (int t = 0; t < NW; t++) step(1'b0, 0, 1'b1, 1'b1, t, 8'hFF, 1'b0, "R7");
        // R7: conditional store in the flush cycle fails although reserved
        step(1'b1, 9, 1'b0, 1'b0, 0, 8'h00, 1'b0, "R7");
        step(1'b0, 0, 1'b1, 1'b1, 9, 8'hFF, 1'b1, "R7");
        // R7: a plain store in the flush cycle still writes
        step(1'b0, 0, 1'b1, 1'b0, 3, 8'h81, 1'b1, "R7");

        // R8: tag and clear on the same word in one cycle, clear wins
        for (int t = 0; t < NW; t += 5) begin
            step(1'b1, t, 1'b1, 1'b0, t, 8'h01, 1'b0, "R8");
            step(1'b0, 0, 1'b1, 1'b1, t, 8'hFF, 1'b0, "R8");
            step(1'b1, t, 1'b0, 1'b0, 0, 8'h00, 1'b1, "R8");
            step(1'b0, 0, 1'b1, 1'b1, t, 8'hFF, 1'b0, "R8");
        end
        // R8: tag on one word while storing another keeps the tag
        step(1'b1, 2, 1'b1, 1'b0, 7, 8'h10, 1'b0, "R8");
        step(1'b0, 0, 1'b1, 1'b1, 2, 8'h3C, 1'b0, "R8");

        idle();
        idle();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule